// File: doc/BRIEF.md
# Filtered Edge-Capture Channel

This block is one channel of a timer capture unit. It picks its input from either a port pin or a quadrature-encoder signal. The input goes through a two-flop synchronizer and then an optional digital noise filter. The filter samples at a rate set by a small predivider. After the filter, the channel detects the edge polarity that has been programmed.

On each valid edge the channel does three things:
- It copies the shared counter value into its own hold register.
- It sets a sticky triggered flag.
- It drives a single-cycle event pulse, which the shared counter logic can use to clear or reload itself.

The channel also drives the current filtered input level and a per-channel interrupt request. The counter itself and the merging of interrupts across channels belong to neighbouring logic.

Top module: `cap_channel`

## Requirements
- R1: Source select picks the input. Code 0 selects `pin_in` and code 2 selects `enc_in`. Codes 1 and 3 are reserved and present a constant low input.
- R2: With the filter active, a new level is accepted only after three consecutive equal samples at the sample rate. A pulse lasting two capture-clock cycles is discarded at divide-by-1.
- R3: The filter sample-rate code on `filt_div_sel` gives these divisions of the capture clock: 0 is /1, 1 is /2, 2 is /4, 3 is /16, 4 is /32, and both 5 and above are /64. For example, a 20-cycle pulse is rejected at /16 and an 80-cycle pulse is accepted.
- R4: When `filt_bypass` is 1, the synchronized input reaches the level register directly, so a two-cycle pulse passes through.
- R5: Edge select works as follows: 00 detects rising edges only, 01 detects falling edges only, and 10 or 11 detects both.
- R6: While `chan_en` is 0, no edge is detected. The flag, the hold register and the event output stay unchanged.
- R7: On a valid edge, `hold_val` takes the value `counter_val` had in the cycle the edge was detected.
- R8: `trig_flag` is set by a valid edge and stays set until a cycle in which `flag_clr` is 1 and no new edge occurs.
- R9: Each valid edge produces exactly one single-cycle high on `cap_event`, in the same cycle that `trig_flag` shows the set.
- R10: `level` always reports the filtered input level of the selected source, whether or not the channel is enabled.
- R11: `irq` is high exactly when `trig_flag` and `irq_en` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | 1 | Port pin input |
| enc_in | input | 1 | Quadrature-encoder signal input |
| src_sel | input | 2 | Source select (0 pin, 2 encoder, 1/3 reserved) |
| chan_en | input | 1 | Channel enable for edge detection |
| filt_bypass | input | 1 | 1 bypasses the noise filter |
| filt_div_sel | input | 3 | Filter sample-rate code |
| edge_sel | input | 2 | Edge polarity select |
| counter_val | input | CNT_W | Shared counter value |
| flag_clr | input | 1 | Write-1 clear of the triggered flag |
| irq_en | input | 1 | Interrupt enable for this channel |
| hold_val | output | CNT_W | Counter value captured at the last edge |
| trig_flag | output | 1 | Sticky triggered flag |
| cap_event | output | 1 | One-cycle capture event pulse |
| level | output | 1 | Filtered input level |
| irq | output | 1 | Channel interrupt request |

## Verification
The assertions assume that `chan_en` and `counter_val` are driven to known values from reset onward. They also assume that `flag_clr` is a level the bench controls and not an unknown. The bench meets these assumptions by driving every input from time zero and by changing inputs only at the falling clock edge. Input pulses are either clearly shorter or clearly longer than three sample periods, so the filter outcome never depends on the phase of the free-running predivider.

// File: rtl/cap_pkg.sv
`timescale 1ns/1ps
package cap_pkg;
    localparam logic [1:0] SRC_PIN = 2'd0;
    localparam logic [1:0] SRC_ENC = 2'd2;

    localparam logic [1:0] EDGE_RISE = 2'b00;
    localparam logic [1:0] EDGE_FALL = 2'b01;

    function automatic int unsigned div_of(input logic [2:0] code);
        case (code)
            3'd0:    div_of = 1;
            3'd1:    div_of = 2;
            3'd2:    div_of = 4;
            3'd3:    div_of = 16;
            3'd4:    div_of = 32;
            default: div_of = 64;
        endcase
    endfunction
endpackage

// File: rtl/cap_sync.sv
`timescale 1ns/1ps
module cap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/cap_tick.sv
`timescale 1ns/1ps
module cap_tick #(
    parameter int MAX_DIV = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] div_sel,
    output logic       tick
);
    import cap_pkg::*;
    localparam int CW = $clog2(MAX_DIV);

    logic [CW-1:0] cnt_d, cnt_q;
    logic [CW-1:0] lim;

    always_comb begin
        lim   = CW'(div_of(div_sel) - 1);
        tick  = 1'b0;
        cnt_d = cnt_q + 1'b1;
        if (cnt_q >= lim) begin
            tick  = 1'b1;
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/cap_filter.sv
`timescale 1ns/1ps
module cap_filter (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    input  logic tick,
    input  logic bypass,
    output logic lvl
);
    typedef struct packed {
        logic [1:0] hist;
        logic       lvl;
    } filt_t;

    filt_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick) begin
            st_d.hist = {st_q.hist[0], din};
            if (din == st_q.hist[0] && din == st_q.hist[1])
                st_d.lvl = din;
        end
        if (bypass)
            st_d.lvl = din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lvl = st_q.lvl;
endmodule

// File: rtl/cap_channel.sv
`timescale 1ns/1ps
module cap_channel #(
    parameter int CNT_W   = 24,
    parameter int MAX_DIV = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_in,
    input  logic             enc_in,
    input  logic [1:0]       src_sel,
    input  logic             chan_en,
    input  logic             filt_bypass,
    input  logic [2:0]       filt_div_sel,
    input  logic [1:0]       edge_sel,
    input  logic [CNT_W-1:0] counter_val,
    input  logic             flag_clr,
    input  logic             irq_en,
    output logic [CNT_W-1:0] hold_val,
    output logic             trig_flag,
    output logic             cap_event,
    output logic             level,
    output logic             irq
);
    import cap_pkg::*;

    typedef struct packed {
        logic             prev;
        logic [CNT_W-1:0] hold;
        logic             flag;
        logic             evt;
    } chan_t;

    chan_t st_d, st_q;
    logic  raw_in, sync_in, tick, filt_lvl;
    logic  rise, fall, hit;

    always_comb begin
        case (src_sel)
            SRC_PIN: raw_in = pin_in;
            SRC_ENC: raw_in = enc_in;
            default: raw_in = 1'b0;
        endcase
    end

    cap_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(raw_in), .dout(sync_in)
    );

    cap_tick #(.MAX_DIV(MAX_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .div_sel(filt_div_sel), .tick(tick)
    );

    cap_filter u_filt (
        .clk(clk), .rst_n(rst_n), .din(sync_in), .tick(tick),
        .bypass(filt_bypass), .lvl(filt_lvl)
    );

    always_comb begin
        st_d      = st_q;
        st_d.prev = filt_lvl;
        rise      = filt_lvl & ~st_q.prev;
        fall      = ~filt_lvl & st_q.prev;
        case (edge_sel)
            EDGE_RISE: hit = rise;
            EDGE_FALL: hit = fall;
            default:   hit = rise | fall;
        endcase
        hit      = hit & chan_en;
        st_d.evt = hit;
        if (flag_clr) st_d.flag = 1'b0;
        if (hit) begin
            st_d.flag = 1'b1;
            st_d.hold = counter_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hold_val  = st_q.hold;
    assign trig_flag = st_q.flag;
    assign cap_event = st_q.evt;
    assign level     = filt_lvl;
    assign irq       = st_q.flag & irq_en;
endmodule

// File: rtl/cap_channel_chk.sv
`timescale 1ns/1ps
module cap_channel_chk #(
    parameter int CNT_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             chan_en,
    input logic [CNT_W-1:0] counter_val,
    input logic             flag_clr,
    input logic [CNT_W-1:0] hold_val,
    input logic             trig_flag,
    input logic             cap_event
);
    // R9
    event_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_event |-> trig_flag);

    // R7
    hold_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_event |-> hold_val == $past(counter_val));

    // R7
    hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_event |-> $stable(hold_val));

    // R6
    disabled_no_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_en |=> !cap_event);

    // R8
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_flag && !flag_clr) |=> trig_flag);

    // R8
    flag_only_by_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trig_flag) |-> cap_event);
endmodule

bind cap_channel cap_channel_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .counter_val(counter_val),
    .flag_clr(flag_clr), .hold_val(hold_val), .trig_flag(trig_flag),
    .cap_event(cap_event)
);

// File: tb/cap_channel_tb.sv
`timescale 1ns/1ps
module cap_channel_tb;
    localparam int CNT_W = 24;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             pin_in = 1'b0;
    logic             enc_in = 1'b0;
    logic [1:0]       src_sel = 2'd0;
    logic             chan_en = 1'b1;
    logic             filt_bypass = 1'b0;
    logic [2:0]       filt_div_sel = 3'd0;
    logic [1:0]       edge_sel = 2'b00;
    logic [CNT_W-1:0] counter_val = '0;
    logic             flag_clr = 1'b0;
    logic             irq_en = 1'b0;
    logic [CNT_W-1:0] hold_val;
    logic             trig_flag, cap_event, level, irq;

    int checks = 0;
    int errors = 0;
    int ev_cnt = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    cap_channel #(.CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .enc_in(enc_in),
        .src_sel(src_sel), .chan_en(chan_en), .filt_bypass(filt_bypass),
        .filt_div_sel(filt_div_sel), .edge_sel(edge_sel),
        .counter_val(counter_val), .flag_clr(flag_clr), .irq_en(irq_en),
        .hold_val(hold_val), .trig_flag(trig_flag), .cap_event(cap_event),
        .level(level), .irq(irq)
    );

    always @(negedge clk) if (rst_n && cap_event) ev_cnt++;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_flag();
        @(negedge clk) flag_clr = 1'b1;
        @(negedge clk) flag_clr = 1'b0;
        ev_cnt = 0;
    endtask

    task automatic pulse_pin(input int width);
        @(negedge clk) pin_in = 1'b1;
        wait_n(width);
        pin_in = 1'b0;
    endtask

    task automatic t_reset();
        check("R8 reset flag", trig_flag, 0);
        check("R7 reset hold", hold_val, 0);
        check("R9 reset event", cap_event, 0);
        check("R10 reset level", level, 0);
    endtask

    task automatic t_rising();
        edge_sel = 2'b00; counter_val = 24'h123456;
        @(negedge clk) pin_in = 1'b1;
        wait_n(20);
        check("R5 rise flag", trig_flag, 1);
        check("R7 hold value", hold_val, 24'h123456);
        check("R9 one event", ev_cnt, 1);
        check("R10 level high", level, 1);
        clear_flag();
        check("R8 flag cleared", trig_flag, 0);
        counter_val = 24'h000111;
        @(negedge clk) pin_in = 1'b0;
        wait_n(20);
        check("R5 fall ignored in rise mode", trig_flag, 0);
        check("R5 hold kept", hold_val, 24'h123456);
    endtask

    task automatic t_falling();
        edge_sel = 2'b01;
        @(negedge clk) pin_in = 1'b1;
        wait_n(20);
        check("R5 rise ignored in fall mode", trig_flag, 0);
        counter_val = 24'hABCDEF;
        @(negedge clk) pin_in = 1'b0;
        wait_n(20);
        check("R5 fall flag", trig_flag, 1);
        check("R7 hold on fall", hold_val, 24'hABCDEF);
        clear_flag();
    endtask

    task automatic t_both();
        for (int code = 2; code < 4; code++) begin
            edge_sel = 2'(code);
            ev_cnt = 0;
            @(negedge clk) pin_in = 1'b1;
            wait_n(20);
            @(negedge clk) pin_in = 1'b0;
            wait_n(20);
            check("R5 both edges", ev_cnt, 2);
            check("R8 flag sticky", trig_flag, 1);
            clear_flag();
        end
    endtask

    task automatic t_disable();
        edge_sel = 2'b10; chan_en = 1'b0; counter_val = 24'h777777;
        @(negedge clk) pin_in = 1'b1;
        wait_n(20);
        check("R10 level while disabled", level, 1);
        @(negedge clk) pin_in = 1'b0;
        wait_n(20);
        check("R6 no flag", trig_flag, 0);
        check("R6 no event", ev_cnt, 0);
        check("R6 hold unchanged", hold_val, 24'hABCDEF);
        chan_en = 1'b1;
    endtask

    task automatic t_source();
        edge_sel = 2'b00;
        src_sel = 2'd2;
        wait_n(10);
        @(negedge clk) pin_in = 1'b1;
        wait_n(20);
        check("R1 pin ignored on encoder source", level, 0);
        @(negedge clk) enc_in = 1'b1;
        wait_n(20);
        check("R1 encoder level", level, 1);
        check("R1 encoder edge", trig_flag, 1);
        clear_flag();
        src_sel = 2'd1;
        wait_n(20);
        check("R1 reserved code 1 low", level, 0);
        src_sel = 2'd3;
        wait_n(20);
        check("R1 reserved code 3 low", level, 0);
        pin_in = 1'b0; enc_in = 1'b0; src_sel = 2'd0;
        wait_n(20);
        clear_flag();
    endtask

    task automatic t_glitch();
        edge_sel = 2'b00; filt_div_sel = 3'd0;
        pulse_pin(2);
        wait_n(20);
        check("R2 short pulse rejected", trig_flag, 0);
        pulse_pin(5);
        wait_n(20);
        check("R2 long pulse accepted", trig_flag, 1);
        clear_flag();
    endtask

    task automatic t_bypass();
        filt_bypass = 1'b1; edge_sel = 2'b10;
        pulse_pin(2);
        wait_n(20);
        check("R4 bypass passes short pulse", ev_cnt, 2);
        clear_flag();
        filt_bypass = 1'b0;
    endtask

    task automatic t_prediv();
        edge_sel = 2'b00;
        filt_div_sel = 3'd3;
        pulse_pin(20);
        wait_n(100);
        check("R3 div16 rejects 20 cycles", trig_flag, 0);
        pulse_pin(80);
        wait_n(100);
        check("R3 div16 accepts 80 cycles", trig_flag, 1);
        clear_flag();
        filt_div_sel = 3'd5;
        pulse_pin(100);
        wait_n(300);
        check("R3 div64 rejects 100 cycles", trig_flag, 0);
        pulse_pin(260);
        wait_n(300);
        check("R3 div64 accepts 260 cycles", trig_flag, 1);
        clear_flag();
        filt_div_sel = 3'd0;
    endtask

    task automatic t_irq();
        edge_sel = 2'b00; irq_en = 1'b0;
        pulse_pin(5);
        wait_n(20);
        check("R11 masked irq", irq, 0);
        irq_en = 1'b1;
        wait_n(1);
        check("R11 irq asserted", irq, 1);
        clear_flag();
        check("R11 irq drops with flag", irq, 0);
        irq_en = 1'b0;
    endtask

    initial begin
        wait_n(5);
        @(negedge clk) rst_n = 1'b1;
        wait_n(5);
        t_reset();
        t_rising();
        t_falling();
        t_both();
        t_disable();
        t_source();
        t_glitch();
        t_bypass();
        t_prediv();
        t_irq();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule